// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block forms the word address that a synchronous pipelined SRAM array sees during a four-beat burst. An address-strobe cycle captures the external address together with the chip-select state. Each later clock edge with the advance input low then moves the two low-order address bits to the next beat. The upper bits stay exactly as captured until the next load.

There are two load strobes. The controller strobe always loads. The processor strobe loads only while the primary chip enable is low. A static mode input picks the order of the low bits. In linear order the start value is counted up modulo four. In interleaved order the start value is XORed with a beat count running 0, 1, 2, 3. In both orders the burst wraps back to its first address after the fourth beat. Cycles with no strobe and no advance leave the address unchanged.

Top module: `burst_addr_gen`

## Requirements
- R1: Outside a load, the address bits above the two low-order bits keep the value captured at the last load.
- R2: On a rising edge with `ctl_stb_n` low, the whole address takes the value of `addr_in`, whatever the level of `ce_n`. `addr_out` shows it from that edge on.
- R3: On a rising edge with `cpu_stb_n` low and `ce_n` low, the address is loaded from `addr_in`. With `ce_n` high, a low `cpu_stb_n` has no effect: `addr_out` and `sel` stay as they were.
- R4: With `seq_linear` = 1, each rising edge with `adv_n` low and no load makes the low two bits the previous value plus one, modulo 4. Example from a start of 2: 2, 3, 0, 1.
- R5: With `seq_linear` = 0, the low two bits equal the loaded start XOR a beat count that starts at 0 at the load and rises by one on each advance. Example from a start of 1: 1, 0, 3, 2.
- R6: On a rising edge with both strobes inactive and `adv_n` high, `addr_out` and `sel` do not change.
- R7: A load takes priority over an advance in the same cycle. It replaces any burst in progress and restarts the beat count at 0.
- R8: An advance after the fourth beat returns the low bits to the loaded start value.
- R9: While `rst_n` is low at a rising edge, the address, the beat count and `sel` clear to 0.
- R10: On every load, `sel` takes the inverse of `ce_n` sampled at that edge, so a controller-strobe load with `ce_n` high gives `sel` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_in | input | ADDR_W | External word address |
| ce_n | input | 1 | Primary chip enable, active low; gates the processor strobe |
| cpu_stb_n | input | 1 | Processor address strobe, active low |
| ctl_stb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| seq_linear | input | 1 | Order select: 1 linear, 0 interleaved |
| addr_out | output | ADDR_W | Internal address to the array |
| sel | output | 1 | Captured chip-select state, active high |

## Verification
The bench targets the wrap after the fourth beat in both orders. A counter that saturates would stall on the last beat, and one that restarts at zero would lose a non-zero start. It issues a processor strobe with the chip enable high: a design that drops the gate reloads the address and changes `sel`. It asserts a strobe together with an advance in the middle of a burst. A design that advances first would show the new start plus one, or the old burst carried on. Wait cycles come with changing `addr_in`, so a design that loads without a strobe shows the new address.

// File: rtl/burst_pkg.sv
`timescale 1ns/1ps
// burst_pkg: types shared by the burst address sequence generator.
// Assumes: nothing beyond the standard language.
package burst_pkg;
    // Order in which the low address bits walk through a burst.
    typedef enum logic {
        SEQ_INTERLEAVE = 1'b0,
        SEQ_LINEAR     = 1'b1
    } seq_mode_e;
endpackage

// File: rtl/burst_addr_reg.sv
`timescale 1ns/1ps
// burst_addr_reg: holds the captured start address and chip-select state.
// Does: loads both on a load pulse and holds them otherwise.
// Assumes: load is already qualified by the strobe and enable logic.
module burst_addr_reg #(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_d,
    input  logic              sel_d,
    output logic [ADDR_W-1:0] base_q,
    output logic              sel_q
);
    // Capture the start address and select state on a load, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            sel_q  <= 1'b0;
        end else if (load) begin
            base_q <= addr_d;
            sel_q  <= sel_d;
        end
    end
endmodule

// File: rtl/burst_beat_ctr.sv
`timescale 1ns/1ps
// burst_beat_ctr: counts the beats of a burst.
// Does: clears on a load, steps on an advance, and wraps modulo 2**BURST_W.
// Assumes: clear and step are never both high (the top gives clear priority).
module burst_beat_ctr #(
    parameter int BURST_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               step,
    output logic [BURST_W-1:0] beat_q
);
    localparam logic [BURST_W-1:0] ONE = {{(BURST_W-1){1'b0}}, 1'b1};

    // Beat register: clear has priority; wrapping comes from the natural overflow.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            beat_q <= '0;
        end else if (step) begin
            beat_q <= beat_q + ONE;
        end
    end
endmodule

// File: rtl/burst_seq_map.sv
`timescale 1ns/1ps
// burst_seq_map: maps a start offset and a beat count to the burst offset.
// Does: linear = start + beat (mod 2**BURST_W); interleaved = start ^ beat.
// Assumes: the mode is static during a burst; this block is purely combinational.
module burst_seq_map
    import burst_pkg::*;
#(
    parameter int BURST_W = 2
) (
    input  seq_mode_e          mode,
    input  logic [BURST_W-1:0] start,
    input  logic [BURST_W-1:0] beat,
    output logic [BURST_W-1:0] offset
);
    logic [BURST_W-1:0] lin_off;
    logic [BURST_W-1:0] ilv_off;

    // Linear order: modular sum of the start offset and the beat count.
    always_comb lin_off = start + beat;

    // Interleaved order: each bit flips independently with its beat bit.
    for (genvar b = 0; b < BURST_W; b++) begin : g_ilv
        assign ilv_off[b] = start[b] ^ beat[b];
    end

    // Select the order picked by the mode input.
    always_comb offset = (mode == SEQ_LINEAR) ? lin_off : ilv_off;
endmodule

// File: rtl/burst_addr_gen.sv
`timescale 1ns/1ps
// burst_addr_gen: burst address sequence generator for a pipelined SRAM.
// Does: loads the address on either strobe (the processor strobe only with
//       ce_n low), steps the low BURST_W bits on advance, and holds otherwise.
// Assumes: ADDR_W > BURST_W; seq_linear is static; all inputs are synchronous.
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W  = 18,
    parameter int BURST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              ce_n,
    input  logic              cpu_stb_n,
    input  logic              ctl_stb_n,
    input  logic              adv_n,
    input  logic              seq_linear,
    output logic [ADDR_W-1:0] addr_out,
    output logic              sel
);
    localparam int UP_W = ADDR_W - BURST_W;

    logic               load;
    logic               step;
    logic [ADDR_W-1:0]  base_q;
    logic [BURST_W-1:0] beat_q;
    logic [BURST_W-1:0] offset;
    seq_mode_e          mode;

    // Qualify the strobes: the controller strobe always loads, the processor strobe only when enabled.
    always_comb load = !ctl_stb_n || (!cpu_stb_n && !ce_n);

    // An advance steps the burst only when no load claims the cycle.
    always_comb step = !adv_n && !load;

    // Turn the static mode pin into the shared enum.
    always_comb mode = seq_linear ? SEQ_LINEAR : SEQ_INTERLEAVE;

    burst_addr_reg #(.ADDR_W(ADDR_W)) u_areg (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .addr_d (addr_in),
        .sel_d  (!ce_n),
        .base_q (base_q),
        .sel_q  (sel)
    );

    burst_beat_ctr #(.BURST_W(BURST_W)) u_beat (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (load),
        .step   (step),
        .beat_q (beat_q)
    );

    burst_seq_map #(.BURST_W(BURST_W)) u_map (
        .mode   (mode),
        .start  (base_q[BURST_W-1:0]),
        .beat   (beat_q),
        .offset (offset)
    );

    // Join the captured upper bits with the sequenced low bits.
    always_comb addr_out = {base_q[ADDR_W-1 -: UP_W], offset};
endmodule

// File: rtl/burst_addr_gen_chk.sv
`timescale 1ns/1ps
// burst_addr_gen_chk: port-level properties of burst_addr_gen.
// Assumes: attached through the bind at the bottom of this file.
module burst_addr_gen_chk #(
    parameter int ADDR_W  = 18,
    parameter int BURST_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr_in,
    input logic              ce_n,
    input logic              cpu_stb_n,
    input logic              ctl_stb_n,
    input logic              adv_n,
    input logic              seq_linear,
    input logic [ADDR_W-1:0] addr_out,
    input logic              sel
);
    localparam logic [BURST_W-1:0] ONE = {{(BURST_W-1){1'b0}}, 1'b1};

    // R2: the controller strobe loads the whole address.
    a_r2_ctl_load: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_stb_n |=> addr_out == $past(addr_in));

    // R3: a processor strobe with the enable high changes nothing.
    a_r3_gated_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_stb_n && ce_n && ctl_stb_n && adv_n) |=> ($stable(addr_out) && $stable(sel)));

    // R6: a wait cycle holds the address and the select state.
    a_r6_wait_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_stb_n && ctl_stb_n && adv_n) |=> ($stable(addr_out) && $stable(sel)));

    // R1: without a load, the upper bits never move.
    a_r1_upper_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_stb_n && ctl_stb_n) |=> $stable(addr_out[ADDR_W-1:BURST_W]));

    // R4: a linear advance adds one to the low bits.
    a_r4_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_linear && !adv_n && cpu_stb_n && ctl_stb_n) |=>
        addr_out[BURST_W-1:0] == ($past(addr_out[BURST_W-1:0]) + ONE));

    // R10: every load copies the inverted enable into sel.
    a_r10_sel_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_stb_n || (!cpu_stb_n && !ce_n)) |=> sel == !$past(ce_n));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_in    (addr_in),
    .ce_n       (ce_n),
    .cpu_stb_n  (cpu_stb_n),
    .ctl_stb_n  (ctl_stb_n),
    .adv_n      (adv_n),
    .seq_linear (seq_linear),
    .addr_out   (addr_out),
    .sel        (sel)
);

// File: tb/burst_addr_gen_test.sv
`timescale 1ns/1ps
module burst_addr_gen_test;
    localparam int AW = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic          ce_n = 1'b1;
    logic          cpu_stb_n = 1'b1;
    logic          ctl_stb_n = 1'b1;
    logic          adv_n = 1'b1;
    logic          seq_linear = 1'b1;
    logic [AW-1:0] addr_out;
    logic          sel;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW), .BURST_W(2)) uut (
        .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .ce_n(ce_n),
        .cpu_stb_n(cpu_stb_n), .ctl_stb_n(ctl_stb_n), .adv_n(adv_n),
        .seq_linear(seq_linear), .addr_out(addr_out), .sel(sel)
    );

    task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock edge, then settle 1 ns past it before sampling or driving.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        cpu_stb_n = 1'b1; ctl_stb_n = 1'b1; adv_n = 1'b1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        tick(); tick();
        check("R9 reset addr", addr_out, '0);
        check("R9 reset sel", {17'b0, sel}, 18'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_linear();
        logic [AW-1:0] a = 18'h2A5F6;    // low bits = 2
        seq_linear = 1'b1; ce_n = 1'b0;
        ctl_stb_n = 1'b0; addr_in = a;
        tick();
        check("R2 ctl load", addr_out, a);
        check("R10 sel after load", {17'b0, sel}, 18'd1);
        idle(); adv_n = 1'b0; addr_in = 18'h01234;
        for (int k = 1; k <= 4; k++) begin
            tick();
            check(k == 4 ? "R8 linear wrap" : "R4 linear step", addr_out,
                  {a[AW-1:2], 2'(a[1:0] + k[1:0])});
        end
        check("R1 upper held", {addr_out[AW-1:2], 2'b0}, {a[AW-1:2], 2'b0});
        idle();
    endtask

    task automatic t_interleave();
        logic [AW-1:0] a = 18'h15551;    // low bits = 1
        seq_linear = 1'b0; ce_n = 1'b0;
        ctl_stb_n = 1'b0; addr_in = a;
        tick();
        check("R5 interleave start", addr_out, a);
        idle(); adv_n = 1'b0;
        for (int k = 1; k <= 4; k++) begin
            tick();
            check(k == 4 ? "R8 interleave wrap" : "R5 interleave step", addr_out,
                  {a[AW-1:2], a[1:0] ^ k[1:0]});
        end
        idle();
    endtask

    task automatic t_wait();
        logic [AW-1:0] held;
        seq_linear = 1'b1; ce_n = 1'b0;
        ctl_stb_n = 1'b0; addr_in = 18'h00F03;
        tick();
        idle(); adv_n = 1'b0;
        tick();                           // low bits 3 -> 0
        held = addr_out;
        idle();
        for (int k = 0; k < 3; k++) begin
            addr_in = 18'h3FFFF - 18'(k);
            ce_n = k[0];
            tick();
            check("R6 wait hold", addr_out, held);
        end
        check("R6 wait sel", {17'b0, sel}, 18'd1);
        ce_n = 1'b0;
    endtask

    task automatic t_cpu_strobe();
        logic [AW-1:0] held;
        seq_linear = 1'b1;
        ce_n = 1'b0; cpu_stb_n = 1'b0; addr_in = 18'h12342;
        tick();
        check("R3 cpu load enabled", addr_out, 18'h12342);
        held = addr_out;
        ce_n = 1'b1; addr_in = 18'h3C3C1;
        tick();
        check("R3 cpu strobe ignored addr", addr_out, held);
        check("R3 cpu strobe ignored sel", {17'b0, sel}, 18'd1);
        idle();
        ctl_stb_n = 1'b0; ce_n = 1'b1; addr_in = 18'h0BEE0;
        tick();
        check("R10 ctl load deselected addr", addr_out, 18'h0BEE0);
        check("R10 ctl load deselected sel", {17'b0, sel}, 18'd0);
        idle(); ce_n = 1'b0;
    endtask

    task automatic t_priority();
        seq_linear = 1'b1; ce_n = 1'b0;
        ctl_stb_n = 1'b0; addr_in = 18'h20000;
        tick();
        idle(); adv_n = 1'b0;
        tick();
        check("R4 before reload", addr_out, 18'h20001);
        cpu_stb_n = 1'b0; ctl_stb_n = 1'b0; addr_in = 18'h1FFF2;
        tick();
        check("R7 load beats advance", addr_out, 18'h1FFF2);
        cpu_stb_n = 1'b1; ctl_stb_n = 1'b1;
        tick();
        check("R7 restart count", addr_out, 18'h1FFF3);
        seq_linear = 1'b0;
        ctl_stb_n = 1'b0; addr_in = 18'h00002;
        tick();
        ctl_stb_n = 1'b1;
        tick();
        check("R7 interleave restart", addr_out, 18'h00003);
        idle();
    endtask

    initial begin
        t_reset();
        t_linear();
        t_interleave();
        t_wait();
        t_cpu_strobe();
        t_priority();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule